// File: doc/BRIEF.md
# Parallel Prefix Carry Adder

This block adds two unsigned N-bit operands and a single carry-in bit and produces an N-bit sum and a carry-out. It is purely combinational: no clock or reset, and the outputs follow the inputs within the same evaluation. N is a power of two and defaults to 32.

The carry-in is handled as an extra column that sits below bit 0. Every column first forms a bitwise generate (operand AND) and propagate (operand OR). A tree of combining cells then merges neighbouring spans. The span width doubles at each level, so log2(N) levels are needed. Each column's carry is the merged generate that reaches down to the carry-in column. Each sum bit is the operand XOR combined with that carry. One further combining cell forms the carry-out from the top column and the prefix below it.

Top module: `ppa_adder`

## Requirements
- R1: `sum_o` equals the low WIDTH bits of the unsigned total `a_i + b_i + cin_i`.
- R2: `cout_o` equals bit WIDTH of the unsigned total `a_i + b_i + cin_i`, meaning the adder overflowed the unsigned range.
- R3: When every bit of `a_i` is 1 and the two remaining addends total 1 (either `b_i` = 1 with `cin_i` = 0, or `b_i` = 0 with `cin_i` = 1), `sum_o` is all zeros and `cout_o` is 1.
- R4: The carry-in acts only through the column below bit 0. With both operands zero and `cin_i` = 1, `sum_o` is 1 (bit 0 set, all other bits clear) and `cout_o` is 0. With `cin_i` = 0 the result is all zeros.
- R5: When no bit position has both operand bits set and `cin_i` = 0, `sum_o` equals `a_i | b_i` and `cout_o` is 0. For example, alternating patterns 1010... plus 0101... give all ones. Adding `cin_i` = 1 to such an all-ones case carries along the whole width and gives a zero sum with `cout_o` = 1.
- R6: The outputs are a function of the present inputs only. There is no state, so a new input set is reflected at the outputs without any clock edge.
- R7: WIDTH may be any power of two from 4 to 64, and R1 and R2 hold at every such width. A width outside that set stops elaboration with an error.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | WIDTH | First unsigned operand |
| b_i | input | WIDTH | Second unsigned operand |
| cin_i | input | 1 | Carry into bit 0 |
| sum_o | output | WIDTH | Low WIDTH bits of the total |
| cout_o | output | 1 | Carry out of the top bit |

## Verification
The embedded checks run whenever the inputs change. They compare the sum and the carry-out against a behavioural add. They check that no merged span which reaches the carry-in column ever reports propagate. They check that each tree level only ever widens generate and only ever narrows propagate. They also check that carry-free operand pairs produce the OR of the operands. The bench scenarios cover the cases that an invariant cannot single out: the full-length carry chains of all-ones plus one, the alternating patterns with and without a carry-in, zero plus zero with a carry-in, and an exhaustive sweep of a 4-bit instance that shows the width parameter is handled correctly.

// File: rtl/ppa_pkg.sv
package ppa_pkg;

    typedef struct packed {
        logic g;
        logic p;
    } gp_t;

    function automatic bit width_ok(input int w);
        return (w >= 4) && (w <= 64) && ((w & (w - 1)) == 0);
    endfunction

endpackage

// File: rtl/ppa_cell.sv
module ppa_cell
    import ppa_pkg::*;
(
    input  gp_t hi_i,
    input  gp_t lo_i,
    output gp_t merged_o
);

    assign merged_o.g = hi_i.g | (hi_i.p & lo_i.g);
    assign merged_o.p = hi_i.p & lo_i.p;

endmodule

// File: rtl/ppa_pg_gen.sv
module ppa_pg_gen
    import ppa_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic             cin_i,
    output gp_t  [WIDTH:0]   col_o,
    output logic [WIDTH-1:0] half_o
);

    // index 0 is the carry-in column; index k+1 is operand bit k
    assign col_o[0].g = cin_i;
    assign col_o[0].p = 1'b0;

    for (genvar k = 0; k < WIDTH; k++) begin : g_col
        assign col_o[k+1].g = a_i[k] & b_i[k];
        assign col_o[k+1].p = a_i[k] | b_i[k];
        assign half_o[k]    = a_i[k] ^ b_i[k];
    end

endmodule

// File: rtl/ppa_prefix_tree.sv
module ppa_prefix_tree
    import ppa_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  gp_t [WIDTH-1:0] col_i,
    output gp_t [WIDTH-1:0] pre_o
);

    localparam int LEVELS = $clog2(WIDTH);

    gp_t [LEVELS:0][WIDTH-1:0] lvl;

    assign lvl[0] = col_i;

    for (genvar l = 0; l < LEVELS; l++) begin : g_lvl
        localparam int DIST = 1 << l;
        for (genvar x = 0; x < WIDTH; x++) begin : g_node
            if (x >= DIST) begin : g_merge
                ppa_cell u_cell (
                    .hi_i     (lvl[l][x]),
                    .lo_i     (lvl[l][x-DIST]),
                    .merged_o (lvl[l+1][x])
                );
            end else begin : g_pass
                assign lvl[l+1][x] = lvl[l][x];
            end
        end
    end

    assign pre_o = lvl[LEVELS];

    // spans grow monotonically: generate never drops, propagate never rises
    always_comb begin
        for (int l = 0; l < LEVELS; l++) begin
            for (int x = 0; x < WIDTH; x++) begin
                assert_gen_grows_R1: assert (!lvl[l][x].g || lvl[l+1][x].g)
                    else $error("generate lost between levels");
                assert_prop_shrinks_R1: assert (!lvl[l+1][x].p || lvl[l][x].p)
                    else $error("propagate gained between levels");
            end
        end
    end

endmodule

// File: rtl/ppa_adder.sv
module ppa_adder
    import ppa_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic             cin_i,
    output logic [WIDTH-1:0] sum_o,
    output logic             cout_o
);

    if (!width_ok(WIDTH)) begin : g_bad_width
        $error("ppa_adder: WIDTH must be a power of two from 4 to 64");
    end

    gp_t  [WIDTH:0]   col;
    gp_t  [WIDTH-1:0] pre;
    gp_t              tail;
    logic [WIDTH-1:0] half;

    ppa_pg_gen #(.WIDTH(WIDTH)) u_pg (
        .a_i    (a_i),
        .b_i    (b_i),
        .cin_i  (cin_i),
        .col_o  (col),
        .half_o (half)
    );

    ppa_prefix_tree #(.WIDTH(WIDTH)) u_tree (
        .col_i (col[WIDTH-1:0]),
        .pre_o (pre)
    );

    // top column merged with the full prefix below it
    ppa_cell u_tail (
        .hi_i     (col[WIDTH]),
        .lo_i     (pre[WIDTH-1]),
        .merged_o (tail)
    );

    for (genvar k = 0; k < WIDTH; k++) begin : g_sum
        assign sum_o[k] = half[k] ^ pre[k].g;
    end

    assign cout_o = tail.g;

    logic [WIDTH:0] ref_total;
    assign ref_total = {1'b0, a_i} + {1'b0, b_i} + {{WIDTH{1'b0}}, cin_i};

    always_comb begin
        assert_sum_matches_R1: assert (sum_o == ref_total[WIDTH-1:0])
            else $error("sum differs from behavioural add");
        assert_cout_matches_R2: assert (cout_o == ref_total[WIDTH])
            else $error("carry-out differs from behavioural add");
        assert_carry_col_passive_R4: assert (!tail.p)
            else $error("span down to carry-in column propagates");
        for (int k = 0; k < WIDTH; k++) begin
            assert_prefix_no_prop_R4: assert (!pre[k].p)
                else $error("prefix to carry-in column propagates");
        end
        if (((a_i & b_i) == '0) && !cin_i) begin
            assert_disjoint_or_R5: assert ((sum_o == (a_i | b_i)) && !cout_o)
                else $error("carry-free operands did not give OR");
        end
    end

endmodule

// File: tb/test_ppa_adder.sv
module test_ppa_adder;

    localparam int CLK_PERIOD = 10;
    localparam int W          = 32;
    localparam int WS         = 4;
    localparam int NV         = 10;
    localparam int NRAND      = 2000;

    localparam logic [31:0] TA [NV] = '{
        32'hFFFF_FFFF, 32'h0000_0000, 32'hAAAA_AAAA, 32'hAAAA_AAAA, 32'h1234_5678,
        32'h8000_0000, 32'hFFFF_FFFF, 32'h7FFF_FFFF, 32'hAAAA_AAAA, 32'h0000_FFFF};
    localparam logic [31:0] TB [NV] = '{
        32'h0000_0001, 32'h0000_0000, 32'h5555_5555, 32'h5555_5555, 32'h8765_4321,
        32'h8000_0000, 32'hFFFF_FFFF, 32'h0000_0001, 32'hAAAA_AAAA, 32'h0000_FFFF};
    localparam logic TC [NV] = '{1'b0, 1'b1, 1'b0, 1'b1, 1'b0,
                                 1'b0, 1'b1, 1'b0, 1'b0, 1'b1};
    localparam logic [31:0] TS [NV] = '{
        32'h0000_0000, 32'h0000_0001, 32'hFFFF_FFFF, 32'h0000_0000, 32'h9999_9999,
        32'h0000_0000, 32'hFFFF_FFFF, 32'h8000_0000, 32'h5555_5554, 32'h0001_FFFF};
    localparam logic TCO [NV] = '{1'b1, 1'b0, 1'b0, 1'b1, 1'b0,
                                  1'b1, 1'b1, 1'b0, 1'b1, 1'b0};

    logic clk = 1'b0;
    logic rst = 1'b1;
    int   checks   = 0;
    int   failures = 0;
    bit   done     = 1'b0;

    logic [W-1:0]  a, b, sum;
    logic          cin, cout;
    logic [WS-1:0] sa, sb, ssum;
    logic          scin, scout;

    always #(CLK_PERIOD/2) clk = ~clk;

    ppa_adder #(.WIDTH(W)) i_ppa_adder (
        .a_i(a), .b_i(b), .cin_i(cin), .sum_o(sum), .cout_o(cout)
    );

    ppa_adder #(.WIDTH(WS)) i_ppa_adder_w4 (
        .a_i(sa), .b_i(sb), .cin_i(scin), .sum_o(ssum), .cout_o(scout)
    );

    task automatic chk(input string tag, input logic [64:0] act, input logic [64:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic apply(input logic [W-1:0] va, input logic [W-1:0] vb, input logic vc);
        @(posedge clk);
        a = va; b = vb; cin = vc;
        @(negedge clk);
    endtask

    initial begin
        a = '0; b = '0; cin = 1'b0;
        sa = '0; sb = '0; scin = 1'b0;
        repeat (2) @(posedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R4: idle inputs give a zero result
        chk("R4 zero inputs", {32'd0, cout, sum}, 65'd0);

        // vector table: R1/R2 (and R3, R4, R5 entries)
        for (int v = 0; v < NV; v++) begin
            apply(TA[v], TB[v], TC[v]);
            chk("R1 table sum", {33'd0, sum}, {33'd0, TS[v]});
            chk("R2 table cout", {64'd0, cout}, {64'd0, TCO[v]});
        end

        // R3: all ones plus one via carry-in
        apply('1, '0, 1'b1);
        chk("R3 ones plus cin", {32'd0, cout, sum}, {32'd0, 1'b1, 32'd0});
        apply('1, 32'd1, 1'b0);
        chk("R3 ones plus one", {32'd0, cout, sum}, {32'd0, 1'b1, 32'd0});

        // R4: zero plus zero with carry-in
        apply('0, '0, 1'b1);
        chk("R4 cin only", {32'd0, cout, sum}, {32'd0, 1'b0, 32'd1});

        // R5: alternating disjoint patterns
        apply(32'h5555_5555, 32'hAAAA_AAAA, 1'b0);
        chk("R5 alternating", {32'd0, cout, sum}, {32'd0, 1'b0, 32'hFFFF_FFFF});
        apply(32'hF0F0_F0F0, 32'h0F0F_0000, 1'b0);
        chk("R5 disjoint or", {32'd0, cout, sum}, {32'd0, 1'b0, 32'hFFFF_F0F0});
        apply(32'h5555_5555, 32'hAAAA_AAAA, 1'b1);
        chk("R5 alternating cin", {32'd0, cout, sum}, {32'd0, 1'b1, 32'd0});

        // R6: inputs changed mid-period, outputs follow with no clock edge
        @(posedge clk);
        a = 32'd100; b = 32'd23; cin = 1'b0;
        #1;
        chk("R6 no clock needed", {32'd0, cout, sum}, {32'd0, 1'b0, 32'd123});
        a = 32'd7; b = 32'd8; cin = 1'b1;
        #1;
        chk("R6 follows inputs", {32'd0, cout, sum}, {32'd0, 1'b0, 32'd16});
        @(negedge clk);

        // R1/R2: random operands against a behavioural add
        for (int r = 0; r < NRAND; r++) begin
            logic [W:0] ref_t;
            logic [W-1:0] ra, rb;
            logic rc;
            ra = $urandom; rb = $urandom; rc = 1'($urandom);
            if (r % 8 == 1) rb = ~ra;
            apply(ra, rb, rc);
            ref_t = {1'b0, ra} + {1'b0, rb} + {32'd0, rc};
            chk("R1 R2 random", {32'd0, cout, sum}, {32'd0, ref_t});
        end

        // R7: exhaustive 4-bit instance
        for (int x = 0; x < 512; x++) begin
            logic [WS:0] ref_s;
            @(posedge clk);
            sa = x[3:0]; sb = x[7:4]; scin = x[8];
            @(negedge clk);
            ref_s = {1'b0, sa} + {1'b0, sb} + {4'd0, scin};
            chk("R7 width 4", {60'd0, scout, ssum}, {60'd0, ref_s});
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule